// File: doc/BRIEF.md
# Programmed-I/O SPI Master

This block is an SPI master that software drives through a 32-bit register bus. Outgoing bytes go into a 16-entry transmit FIFO and incoming bytes are collected in a 16-entry receive FIFO, each one byte wide. Two separate down-counters set the length of a transfer: one for bytes still to send and one for bytes still to capture. Shifting starts only when three things are set together: the serial-clock gate, the controller enable and the programmed-I/O enable.

A driver configures the divider and clock gate, then clears the programmed-I/O enable. It loads both byte counts, preloads some transmit data and sets the programmed-I/O enable. While the transfer runs it polls the packed FIFO-level register, tops up the transmit FIFO and empties the receive FIFO. When both counts reach zero, a sticky completion flag is raised. The driver clears it by writing the flag value back.

Chip select has two modes. In the first it follows a pin bit written by software and keeps its level between transfers. In the second it is asserted automatically while a transfer is pending or running.

Top module: `spi_pio_master`

## Requirements
- R1: After reset, cs_n is high, sck and mosi are low, the status register reads 0, the FIFO-level register reads 0 and the divider register reads 4 (a divider of 2).
- R2: The register offsets are: 0x00 clock gate, 0x04 control, 0x08 status, 0x0C pin, 0x10 TX data, 0x20 RX data, 0x30 divider, 0x34 RX count, 0x4C TX count, 0x10C FIFO level, 0x150 shift config and 0x154 pin config.
- R3: The transmit and receive FIFOs each hold 16 bytes. A write to TX data pushes bits 7:0, and a read of RX data returns the oldest byte in bits 7:0 and pops it. The FIFO-level register holds the TX occupancy in bits 15:8 and the RX occupancy in bits 31:24, with all other bits zero.
- R4: A TX data write while the TX FIFO holds 16 bytes is dropped and sets status bit 1.
- R5: A new byte starts only while the clock gate register holds 0xD in bits 3:0, control bit 18 is set and control bit 5 is set. With any of these missing, sck stays low and the FIFOs are untouched.
- R6: Shifting uses SPI mode 0 with the MSB first. sck idles low and MISO is sampled on the rising edge. Each sck phase lasts N core clocks, where N is divider register bits 11:1 and values below 2 count as 2.
- R7: The TX and RX count registers each drop by one per completed byte in which they take part. With the TX count at zero and the RX count nonzero, zero bytes are shifted out. With the RX count at zero, received bytes are discarded.
- R8: If the TX count is nonzero and the TX FIFO is empty, sck stays idle until a byte is written, and no byte is lost.
- R9: If the RX count is nonzero and the RX FIFO is full, shifting pauses until software pops a byte.
- R10: Status bit 0 is set when a completed byte leaves both counts at zero. Writing 1 to a status bit clears it.
- R11: With shift-config bit 24 clear and pin-config bit 1 set, cs_n follows pin register bit 1 (1 drives it high) and keeps that level through and between transfers.
- R12: In any other case, cs_n is low while a byte is in flight or while shifting is enabled with a nonzero count, and high otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (pops RX data) |
| bus_addr | input | 12 | Register byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Active-low chip select |

## Verification
The serial loop returns the inverted MOSI level as MISO, so every received byte must be the complement of the byte sent. A bit-order or sampling-edge error therefore shows up in both directions. Transfers are run with equal counts, with transmit-only counts and with receive-only counts to separate the roles of the two counters. Two cases starve the engine on purpose: a transmit FIFO left empty mid-transfer and a receive FIFO left full. These show that sck holds and that no byte is dropped. Measuring the sck high time at divider fields of 3, 5 and 0 separates correct phase timing from an off-by-one or a missing clamp. Comparing the manual and automatic chip-select modes shows which control bits pick the mode.

// File: rtl/spi_pio_pkg.sv
// Package: register offsets and bit positions shared by the SPI master
// and its checker. Assumes byte offsets on a 12-bit address.
package spi_pio_pkg;
    localparam int ADDR_W = 12;

    localparam logic [ADDR_W-1:0] OFS_CLKGATE  = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_CTRL     = 12'h004;
    localparam logic [ADDR_W-1:0] OFS_STATUS   = 12'h008;
    localparam logic [ADDR_W-1:0] OFS_PIN      = 12'h00C;
    localparam logic [ADDR_W-1:0] OFS_TXDATA   = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_RXDATA   = 12'h020;
    localparam logic [ADDR_W-1:0] OFS_DIV      = 12'h030;
    localparam logic [ADDR_W-1:0] OFS_RXCNT    = 12'h034;
    localparam logic [ADDR_W-1:0] OFS_TXCNT    = 12'h04C;
    localparam logic [ADDR_W-1:0] OFS_LEVEL    = 12'h10C;
    localparam logic [ADDR_W-1:0] OFS_SHIFTCFG = 12'h150;
    localparam logic [ADDR_W-1:0] OFS_PINCFG   = 12'h154;

    localparam int BIT_CTRL_EN   = 18;
    localparam int BIT_CTRL_PIO  = 5;
    localparam int BIT_PIN_CS    = 1;
    localparam int BIT_OVERRIDE  = 24;
    localparam int BIT_KEEP      = 1;
    localparam logic [3:0] CLK_ON_CODE = 4'hD;
endpackage

// File: rtl/spi_byte_fifo.sv
// Synchronous FIFO with occupancy count. Pushes while full and pops
// while empty are ignored. Assumes DEPTH is a power of two.
module spi_byte_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 16,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     din,
    input  logic             pop,
    output logic [W-1:0]     dout,
    output logic             full,
    output logic             empty,
    output logic [LVL_W-1:0] level
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             do_push, do_pop;

    assign full    = (level == LVL_W'(DEPTH));
    assign empty   = (level == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rd_ptr];

    // Storage write; no reset needed on the data array.
    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    // Pointer and occupancy update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (do_push) wr_ptr <= wr_ptr + PTR_W'(1);
            if (do_pop)  rd_ptr <= rd_ptr + PTR_W'(1);
            level <= level + LVL_W'(do_push) - LVL_W'(do_pop);
        end
    end
endmodule

// File: rtl/spi_shift_engine.sv
// Mode-0 MSB-first byte shifter with built-in phase divider. A byte
// starts only when enabled, a count is pending, TX data is present if
// needed and RX space exists if needed; an in-flight byte always ends.
module spi_shift_engine #(
    parameter int DIV_W = 11
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_field,
    input  logic             tx_need,
    input  logic             rx_need,
    input  logic             tx_empty,
    input  logic             rx_full,
    input  logic [7:0]       tx_byte,
    input  logic             miso,
    output logic             tx_pop,
    output logic             rx_push,
    output logic             tx_done,
    output logic [7:0]       rx_byte,
    output logic             busy,
    output logic             sck,
    output logic             mosi
);
    localparam logic [DIV_W-1:0] MIN_DIV = DIV_W'(2);

    logic [DIV_W-1:0] div_eff, ph_cnt;
    logic [7:0]       out_sr, in_sr;
    logic [2:0]       bit_idx;
    logic             tx_en, rx_en;
    logic             start, phase_end, last_edge;

    assign div_eff   = (div_field < MIN_DIV) ? MIN_DIV : div_field;
    assign start     = !busy && run && (tx_need || rx_need)
                     && (!tx_need || !tx_empty) && (!rx_need || !rx_full);
    assign phase_end = busy && (ph_cnt >= div_eff - DIV_W'(1));
    assign last_edge = phase_end && sck && (bit_idx == 3'd7);

    assign tx_pop  = start && tx_need;
    assign rx_push = last_edge && rx_en;
    assign tx_done = last_edge && tx_en;
    assign rx_byte = in_sr;
    assign mosi    = busy && out_sr[7];

    // Byte sequencer: load, toggle sck per phase, sample on rise, shift on fall.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            sck     <= 1'b0;
            ph_cnt  <= '0;
            bit_idx <= '0;
            out_sr  <= '0;
            in_sr   <= '0;
            tx_en   <= 1'b0;
            rx_en   <= 1'b0;
        end else if (start) begin
            busy    <= 1'b1;
            sck     <= 1'b0;
            ph_cnt  <= '0;
            bit_idx <= '0;
            out_sr  <= tx_need ? tx_byte : 8'h00;
            tx_en   <= tx_need;
            rx_en   <= rx_need;
        end else if (phase_end) begin
            ph_cnt <= '0;
            if (!sck) begin
                sck   <= 1'b1;
                in_sr <= {in_sr[6:0], miso};
            end else begin
                sck <= 1'b0;
                if (bit_idx == 3'd7) begin
                    busy <= 1'b0;
                end else begin
                    bit_idx <= bit_idx + 3'd1;
                    out_sr  <= {out_sr[6:0], 1'b0};
                end
            end
        end else if (busy) begin
            ph_cnt <= ph_cnt + DIV_W'(1);
        end
    end
endmodule

// File: rtl/spi_pio_master.sv
// Top: register file, byte counters, status flags and chip-select control
// around two byte FIFOs and the shift engine. Assumes single-cycle bus
// strobes; reads are combinational and only RX data has a side effect.
module spi_pio_master
    import spi_pio_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 16,
    parameter int DIV_W      = 11,
    localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              sck,
    output logic              mosi,
    input  logic              miso,
    output logic              cs_n
);
    logic [3:0]       clk_gate;
    logic             ctrl_en, ctrl_pio, pin_cs, cs_override, cs_keep;
    logic             st_done, st_ovf;
    logic [DIV_W-1:0] div_field;
    logic [CNT_W-1:0] tx_cnt, rx_cnt, tx_next, rx_next;

    logic             tx_full, tx_empty, rx_full, rx_empty;
    logic [LVL_W-1:0] tx_lvl, rx_lvl;
    logic [7:0]       tx_head, rx_head, rx_byte;
    logic             tx_push, tx_pop, rx_push, rx_pop, tx_done;
    logic             ovf_evt, done_evt, run, eng_busy, manual_mode, auto_active;
    logic             wr_status, wr_pin;
    logic             unused_bits;

    assign unused_bits = ^{bus_wdata[31:25], bus_wdata[23:19], bus_wdata[17:16],
                           bus_wdata[0], rx_empty};

    assign run       = (clk_gate == CLK_ON_CODE) && ctrl_en && ctrl_pio;
    assign tx_push   = bus_wr && (bus_addr == OFS_TXDATA);
    assign ovf_evt   = tx_push && tx_full;
    assign rx_pop    = bus_rd && (bus_addr == OFS_RXDATA);
    assign wr_status = bus_wr && (bus_addr == OFS_STATUS);
    assign wr_pin    = bus_wr && (bus_addr == OFS_PIN);
    assign tx_next   = tx_cnt - CNT_W'(tx_done);
    assign rx_next   = rx_cnt - CNT_W'(rx_push);
    assign done_evt  = (tx_done || rx_push) && (tx_next == '0) && (rx_next == '0);
    assign manual_mode = cs_keep && !cs_override;
    assign auto_active = eng_busy || (run && ((tx_cnt != '0) || (rx_cnt != '0)));

    spi_byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .push(tx_push), .din(bus_wdata[7:0]),
        .pop(tx_pop), .dout(tx_head), .full(tx_full), .empty(tx_empty),
        .level(tx_lvl));

    spi_byte_fifo #(.W(8), .DEPTH(FIFO_DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .push(rx_push), .din(rx_byte),
        .pop(rx_pop), .dout(rx_head), .full(rx_full), .empty(rx_empty),
        .level(rx_lvl));

    spi_shift_engine #(.DIV_W(DIV_W)) u_eng (
        .clk(clk), .rst_n(rst_n), .run(run), .div_field(div_field),
        .tx_need(tx_cnt != '0), .rx_need(rx_cnt != '0),
        .tx_empty(tx_empty), .rx_full(rx_full), .tx_byte(tx_head),
        .miso(miso), .tx_pop(tx_pop), .rx_push(rx_push), .tx_done(tx_done),
        .rx_byte(rx_byte), .busy(eng_busy), .sck(sck), .mosi(mosi));

    // Plain configuration registers written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            clk_gate    <= '0;
            ctrl_en     <= 1'b0;
            ctrl_pio    <= 1'b0;
            pin_cs      <= 1'b1;
            cs_override <= 1'b0;
            cs_keep     <= 1'b0;
            div_field   <= DIV_W'(2);
        end else if (bus_wr) begin
            case (bus_addr)
                OFS_CLKGATE:  clk_gate <= bus_wdata[3:0];
                OFS_CTRL: begin
                    ctrl_en  <= bus_wdata[BIT_CTRL_EN];
                    ctrl_pio <= bus_wdata[BIT_CTRL_PIO];
                end
                OFS_PIN:      pin_cs      <= bus_wdata[BIT_PIN_CS];
                OFS_DIV:      div_field   <= bus_wdata[DIV_W:1];
                OFS_SHIFTCFG: cs_override <= bus_wdata[BIT_OVERRIDE];
                OFS_PINCFG:   cs_keep     <= bus_wdata[BIT_KEEP];
                default: ;
            endcase
        end
    end

    // Byte counters: bus write wins, otherwise count down per finished byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tx_cnt <= '0;
            rx_cnt <= '0;
        end else begin
            if (bus_wr && bus_addr == OFS_TXCNT) tx_cnt <= bus_wdata[CNT_W-1:0];
            else                                 tx_cnt <= tx_next;
            if (bus_wr && bus_addr == OFS_RXCNT) rx_cnt <= bus_wdata[CNT_W-1:0];
            else                                 rx_cnt <= rx_next;
        end
    end

    // Sticky status flags, write-one-to-clear; a new event wins over a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_done <= 1'b0;
            st_ovf  <= 1'b0;
        end else begin
            if (done_evt)                      st_done <= 1'b1;
            else if (wr_status && bus_wdata[0]) st_done <= 1'b0;
            if (ovf_evt)                       st_ovf  <= 1'b1;
            else if (wr_status && bus_wdata[1]) st_ovf  <= 1'b0;
        end
    end

    // Registered chip select: software pin in manual mode, else automatic.
    always_ff @(posedge clk) begin
        if (!rst_n) cs_n <= 1'b1;
        else        cs_n <= manual_mode ? pin_cs : !auto_active;
    end

    // Combinational read mux.
    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            OFS_CLKGATE:  bus_rdata[3:0] = clk_gate;
            OFS_CTRL: begin
                bus_rdata[BIT_CTRL_EN]  = ctrl_en;
                bus_rdata[BIT_CTRL_PIO] = ctrl_pio;
            end
            OFS_STATUS:   bus_rdata[1:0] = {st_ovf, st_done};
            OFS_PIN:      bus_rdata[BIT_PIN_CS] = pin_cs;
            OFS_RXDATA:   bus_rdata[7:0] = rx_head;
            OFS_DIV:      bus_rdata[DIV_W:1] = div_field;
            OFS_RXCNT:    bus_rdata[CNT_W-1:0] = rx_cnt;
            OFS_TXCNT:    bus_rdata[CNT_W-1:0] = tx_cnt;
            OFS_LEVEL: begin
                bus_rdata[31:24] = 8'(rx_lvl);
                bus_rdata[15:8]  = 8'(tx_lvl);
            end
            OFS_SHIFTCFG: bus_rdata[BIT_OVERRIDE] = cs_override;
            OFS_PINCFG:   bus_rdata[BIT_KEEP] = cs_keep;
            default: ;
        endcase
    end
endmodule

// File: rtl/spi_pio_master_chk.sv
// Checker bound to spi_pio_master: relates bus activity, FIFO state,
// engine state and the serial pins over time.
module spi_pio_master_chk
    import spi_pio_pkg::*;
#(
    parameter int FIFO_DEPTH = 16,
    parameter int CNT_W      = 16,
    parameter int LVL_W      = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              sck,
    input logic              mosi,
    input logic              cs_n,
    input logic [CNT_W-1:0]  tx_cnt,
    input logic [LVL_W-1:0]  tx_lvl,
    input logic [LVL_W-1:0]  rx_lvl,
    input logic              tx_full,
    input logic              st_ovf,
    input logic              eng_busy,
    input logic              manual_mode,
    input logic              wr_pin
);
    assert_fifo_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_lvl <= LVL_W'(FIFO_DEPTH)) && (rx_lvl <= LVL_W'(FIFO_DEPTH)));

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == OFS_TXDATA && tx_full) |=> st_ovf);

    assert_sck_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !eng_busy |-> !sck);

    assert_mosi_steady_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sck && $past(sck)) |-> $stable(mosi));

    assert_txcnt_no_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_addr == OFS_TXCNT) |=> (tx_cnt <= $past(tx_cnt)));

    assert_cs_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (manual_mode && $past(manual_mode) && !wr_pin && !$past(wr_pin))
        |=> $stable(cs_n));
endmodule

bind spi_pio_master spi_pio_master_chk #(
    .FIFO_DEPTH(FIFO_DEPTH), .CNT_W(CNT_W), .LVL_W(LVL_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .sck(sck), .mosi(mosi), .cs_n(cs_n), .tx_cnt(tx_cnt),
    .tx_lvl(tx_lvl), .rx_lvl(rx_lvl), .tx_full(tx_full), .st_ovf(st_ovf),
    .eng_busy(eng_busy), .manual_mode(manual_mode), .wr_pin(wr_pin)
);

// File: tb/spi_pio_master_test.sv
// Directed bench: one task per scenario; MISO loops back inverted MOSI.
module spi_pio_master_test;
    import spi_pio_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        sck, mosi, miso, cs_n;

    int checks = 0, fails = 0;
    int edges = 0, nbits = 0, mon_n = 0, cs_bad = 0, hi_run = 0, last_hi = 0;
    logic [7:0] cap = '0;
    logic [7:0] mon [128];

    localparam logic [31:0] RUN_BITS = 32'h0004_0020;
    localparam logic [31:0] EN_ONLY  = 32'h0004_0000;

    always #4 clk = ~clk;
    assign miso = ~mosi;

    spi_pio_master uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .sck(sck), .mosi(mosi), .miso(miso), .cs_n(cs_n));

    // Serial monitor: count edges, capture MOSI bytes, watch CS.
    always @(posedge sck) begin
        edges = edges + 1;
        cap = {cap[6:0], mosi};
        nbits = nbits + 1;
        if (cs_n) cs_bad = cs_bad + 1;
        if (nbits == 8) begin
            mon[mon_n % 128] = cap;
            mon_n = mon_n + 1;
            nbits = 0;
        end
    end

    // SCK high-time measurement in core clocks.
    always @(posedge clk) begin
        if (sck) hi_run = hi_run + 1;
        else begin
            if (hi_run != 0) last_hi = hi_run;
            hi_run = 0;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_done();
        logic [31:0] s;
        for (int i = 0; i < 4000; i++) begin
            rd(OFS_STATUS, s);
            if (s[0]) break;
        end
        check("R10 done flag", {31'b0, s[0]}, 32'd1);
        wr(OFS_STATUS, 32'h1);
    endtask

    task automatic setup(input logic [31:0] divreg, input int txc, input int rxc);
        wr(OFS_CTRL, EN_ONLY);
        wr(OFS_CLKGATE, 32'hD);
        wr(OFS_DIV, divreg);
        wr(OFS_TXCNT, txc);
        wr(OFS_RXCNT, rxc);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 cs_n", {31'b0, cs_n}, 32'd1);
        check("R1 sck/mosi", {30'b0, sck, mosi}, 32'd0);
        rd(OFS_STATUS, d); check("R1 status", d, 32'd0);
        rd(OFS_LEVEL, d);  check("R1 level", d, 32'd0);
        rd(OFS_DIV, d);    check("R1 R2 divider", d, 32'd4);
    endtask

    task automatic t_overflow();
        logic [31:0] d;
        int base;
        setup(32'd4, 16, 0);
        for (int i = 0; i < 3; i++) wr(OFS_TXDATA, 32'hAB00 + i);
        rd(OFS_LEVEL, d); check("R3 tx level 3", d, 32'h0000_0300);
        for (int i = 3; i < 16; i++) wr(OFS_TXDATA, i);
        wr(OFS_TXDATA, 32'hEE);
        rd(OFS_LEVEL, d);  check("R4 level stays 16", d, 32'h0000_1000);
        rd(OFS_STATUS, d); check("R4 overflow flag", d, 32'h2);
        wr(OFS_STATUS, d);
        rd(OFS_STATUS, d); check("R10 w1c clear", d, 32'h0);
        base = mon_n;
        wr(OFS_CTRL, RUN_BITS);
        wait_done();
        check("R4 bytes sent", mon_n - base, 32'd16);
        check("R3 first byte low bits", {24'b0, mon[base % 128]}, 32'h00);
        check("R4 last byte not dropped one", {24'b0, mon[(base + 15) % 128]}, 32'h0F);
    endtask

    task automatic t_basic();
        logic [31:0] d;
        logic [7:0] pat [3] = '{8'hA5, 8'h3C, 8'h81};
        int base;
        setup(32'd6, 3, 3);
        for (int i = 0; i < 3; i++) wr(OFS_TXDATA, pat[i]);
        base = mon_n;
        wr(OFS_CTRL, RUN_BITS);
        wait_done();
        rd(OFS_LEVEL, d); check("R3 rx level 3", d, 32'h0300_0000);
        for (int i = 0; i < 3; i++) begin
            check("R6 mosi msb first", {24'b0, mon[(base + i) % 128]}, {24'b0, pat[i]});
            rd(OFS_RXDATA, d);
            check("R6 R7 rx byte", d, {24'b0, ~pat[i]});
        end
        check("R6 half period div3", last_hi, 32'd3);
        rd(OFS_TXCNT, d); check("R7 tx count zero", d, 32'd0);
        check("R12 cs idle after", {31'b0, cs_n}, 32'd1);
    endtask

    task automatic t_gating();
        logic [31:0] d;
        int e0;
        setup(32'd4, 1, 0);
        wr(OFS_TXDATA, 32'h77);
        e0 = edges;
        repeat (100) @(negedge clk);
        check("R5 no pio enable", edges - e0, 32'd0);
        wr(OFS_CLKGATE, 32'h0);
        wr(OFS_CTRL, RUN_BITS);
        repeat (100) @(negedge clk);
        check("R5 clock gated", edges - e0, 32'd0);
        rd(OFS_LEVEL, d); check("R5 tx fifo untouched", d, 32'h0000_0100);
        wr(OFS_CLKGATE, 32'hD);
        wait_done();
        check("R5 runs when enabled", edges - e0, 32'd8);
    endtask

    task automatic t_tx_stall();
        logic [31:0] d;
        int e0;
        setup(32'd4, 2, 2);
        wr(OFS_TXDATA, 32'h5A);
        e0 = edges;
        wr(OFS_CTRL, RUN_BITS);
        repeat (200) @(negedge clk);
        check("R8 one byte then stall", edges - e0, 32'd8);
        check("R8 sck idle low", {31'b0, sck}, 32'd0);
        check("R12 cs low while pending", {31'b0, cs_n}, 32'd0);
        rd(OFS_STATUS, d); check("R8 not done", d, 32'd0);
        wr(OFS_TXDATA, 32'hC3);
        wait_done();
        rd(OFS_RXDATA, d); check("R8 rx first", d, 32'hA5);
        rd(OFS_RXDATA, d); check("R8 rx second", d, 32'h3C);
    endtask

    task automatic t_rx_full();
        logic [31:0] d;
        int e0, base;
        setup(32'd4, 0, 18);
        e0 = edges; base = mon_n;
        wr(OFS_CTRL, RUN_BITS);
        repeat (800) @(negedge clk);
        rd(OFS_LEVEL, d); check("R9 rx fifo full", d, 32'h1000_0000);
        check("R9 paused after 16", edges - e0, 32'd128);
        check("R7 zeros sent", {24'b0, mon[base % 128]}, 32'h00);
        rd(OFS_RXDATA, d); check("R7 rx of zeros", d, 32'hFF);
        rd(OFS_RXDATA, d);
        wait_done();
        rd(OFS_LEVEL, d); check("R9 resumed", d, 32'h1000_0000);
        for (int i = 0; i < 16; i++) rd(OFS_RXDATA, d);
        rd(OFS_LEVEL, d); check("R3 drained", d, 32'h0);
    endtask

    task automatic t_rx_off();
        logic [31:0] d;
        int base;
        setup(32'd4, 2, 0);
        wr(OFS_TXDATA, 32'h11); wr(OFS_TXDATA, 32'h22);
        base = mon_n;
        wr(OFS_CTRL, RUN_BITS);
        wait_done();
        rd(OFS_LEVEL, d); check("R7 rx discarded", d, 32'h0);
        check("R7 tx sent", {mon[base % 128], mon[(base + 1) % 128]}, 32'h1122);
    endtask

    task automatic t_cs();
        logic [31:0] d;
        wr(OFS_PINCFG, 32'h2);
        wr(OFS_PIN, 32'h0);
        @(negedge clk);
        check("R11 manual low", {31'b0, cs_n}, 32'd0);
        setup(32'd4, 1, 0);
        wr(OFS_TXDATA, 32'h99);
        wr(OFS_CTRL, RUN_BITS);
        wait_done();
        check("R11 held after transfer", {31'b0, cs_n}, 32'd0);
        wr(OFS_PIN, 32'h2);
        @(negedge clk);
        check("R11 manual high", {31'b0, cs_n}, 32'd1);
        wr(OFS_SHIFTCFG, 32'h0100_0000);
        wr(OFS_PIN, 32'h0);
        @(negedge clk);
        check("R12 override ignores pin", {31'b0, cs_n}, 32'd1);
        wr(OFS_SHIFTCFG, 32'h0);
        wr(OFS_PINCFG, 32'h0);
        @(negedge clk);
        check("R12 auto idle high", {31'b0, cs_n}, 32'd1);
        rd(OFS_PIN, d); check("R2 pin readback", d, 32'h0);
    endtask

    task automatic t_divider();
        setup(32'd10, 1, 0);
        wr(OFS_TXDATA, 32'h0F);
        wr(OFS_CTRL, RUN_BITS);
        wait_done();
        check("R6 half period div5", last_hi, 32'd5);
        setup(32'd0, 1, 0);
        wr(OFS_TXDATA, 32'hF0);
        wr(OFS_CTRL, RUN_BITS);
        wait_done();
        check("R6 clamp to 2", last_hi, 32'd2);
        check("R12 cs low at every edge", cs_bad, 32'd0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_overflow();
        t_basic();
        t_gating();
        t_tx_stall();
        t_rx_full();
        t_rx_off();
        t_cs();
        t_divider();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule